// File: doc/BRIEF.md
# Parallel Printer Port Host Register File

This block is the host-side register set of a byte-wide parallel printer port. A CPU reaches it over a simple I/O bus: an address, separate write and read strobes, a byte-size qualifier and 8-bit write and read data. Only the three lowest address bits select a register, so the block can sit at any aligned eight-byte window. On the printer side it latches the output data byte and drives it onto the data pins. It also drives the control lines with a one-cycle update strobe, presents the live status lines to the CPU, and turns a falling edge on the acknowledge line into a level interrupt request.

The data pins can be turned around. A control bit disables the output drivers. While that bit is set, a data read returns the byte on the input pins instead of the latch. Two further byte registers hold an extended-mode address and an extended-mode data value. They are plain storage here, and no bus cycle is generated from them. The acknowledge interrupt is gated by a control bit. Software clears it by reading the status register.

Top module: `pport_host_regs`

## Requirements
- R1: Only `bus_addr[2:0]` selects a register: offset 0 data, 1 status, 2 control, 3 extended address, 4 extended data. Higher address bits have no effect.
- R2: A read of offset 5, 6 or 7 returns 0xFF. Writes to offsets 1, 5, 6 and 7 change no register and no pin.
- R3: A byte write to offset 0 stores the byte and presents it on `pin_dout` from the next cycle. `pin_dout` changes at no other time. `pin_doe` is high exactly when control bit 5 is 0.
- R4: A data read returns the stored byte when control bit 5 is 0, and the current `pin_din` when it is 1.
- R5: A control write stores the written byte with bits 7 and 6 forced to 1. A control read returns the stored value. `pin_ctrl` always shows it.
- R6: `pin_ctrl_upd` pulses for one cycle after a control write only when the forced value differs from the stored one. Otherwise `pin_ctrl` stays unchanged and no pulse occurs.
- R7: A status read returns the current `pin_status` byte unchanged: bit 7 busy, bit 6 acknowledge, bit 5 paper out, bit 4 selected, bit 3 error, bit 2 interrupt, bit 0 timeout.
- R8: A falling edge of `pin_ack` passes through a two-stage synchronizer and becomes a one-cycle event. `irq` rises on the third rising clock edge after `pin_ack` falls, and only when control bit 4 is 1.
- R9: A byte read of the status register drops `irq` on the next cycle. If an acknowledge event falls in the same cycle and is enabled, `irq` is set instead.
- R10: While `bus_byte` is 0, writes are ignored and reads return 0xFF without clearing `irq`.
- R11: After reset the data latch is 0x00, control is 0xC0, both extended registers are 0x00 and `irq` is 0. `rst_n` is asynchronous active low, and its release is synchronized by two flops.
- R12: The extended address and extended data registers store any byte written and return it on read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | BUS_AW (16) | Bus address; low three bits decoded |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_byte | input | 1 | Access is a single byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| pin_dout | output | 8 | Data pins, output value |
| pin_doe | output | 1 | Data pin output enable |
| pin_din | input | 8 | Data pins, input value |
| pin_ctrl | output | 8 | Control lines |
| pin_ctrl_upd | output | 1 | One-cycle strobe when control lines change |
| pin_status | input | 8 | Status lines |
| pin_ack | input | 1 | Acknowledge line, asynchronous |
| irq | output | 1 | Level interrupt request |

## Verification
The two functions that can meet in one cycle are the acknowledge event setting `irq` and a status read clearing it. The bench drops `pin_ack` and then issues the status read two falling clock edges later. That read lands in the cycle where the synchronized edge event is active. The collision is judged by `irq` being high afterwards. A lone status read must then bring it low, and a status read without the byte qualifier must leave it high.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int DATA_W = 8;
  localparam int OFF_W  = 3;

  typedef enum logic [OFF_W-1:0] {
    OFF_DATA   = 3'd0,
    OFF_STATUS = 3'd1,
    OFF_CTRL   = 3'd2,
    OFF_XADDR  = 3'd3,
    OFF_XDATA  = 3'd4
  } off_e;

  localparam int CTRL_BIDIR_BIT = 5;
  localparam int CTRL_ACKIE_BIT = 4;

  localparam logic [DATA_W-1:0] CTRL_FORCE_ONES = 8'hC0;
  localparam logic [DATA_W-1:0] CTRL_RESET_VAL  = 8'hC0;
  localparam logic [DATA_W-1:0] RD_UNMAPPED     = 8'hFF;
endpackage

// File: rtl/pport_ack_edge.sv
module pport_ack_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_async,
  output logic ack_fall
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], ack_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
    end else begin
      chain_q <= chain_d;
    end
  end

  // chain_q[SYNC_STAGES] is the previous synchronized sample
  assign ack_fall = chain_q[SYNC_STAGES] & ~chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/pport_ctrl_reg.sv
module pport_ctrl_reg
  import pport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              upd_q
);
  logic [DATA_W-1:0] forced;
  logic              changed;
  logic [DATA_W-1:0] ctrl_d;
  logic              upd_d;

  always_comb begin
    forced  = wdata | CTRL_FORCE_ONES;
    changed = wr_en && (forced != ctrl_q);
    ctrl_d  = changed ? forced : ctrl_q;
    upd_d   = changed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET_VAL;
      upd_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      upd_q  <= upd_d;
    end
  end
endmodule

// File: rtl/pport_irq.sv
module pport_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic irq_q
);
  logic irq_d;

  always_comb begin
    irq_d = irq_q;
    if (clr_req) irq_d = 1'b0;
    if (set_req) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/pport_host_regs.sv
module pport_host_regs
  import pport_pkg::*;
#(
  parameter int BUS_AW      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_byte,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] pin_dout,
  output logic              pin_doe,
  input  logic [DATA_W-1:0] pin_din,
  output logic [DATA_W-1:0] pin_ctrl,
  output logic              pin_ctrl_upd,
  input  logic [DATA_W-1:0] pin_status,
  input  logic              pin_ack,
  output logic              irq
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [OFF_W-1:0] off;
  logic             wr_ok, rd_ok;
  logic             wr_data, wr_ctrl, wr_xaddr, wr_xdata, rd_status;

  always_comb begin
    off       = bus_addr[OFF_W-1:0];
    wr_ok     = bus_wr && bus_byte;
    rd_ok     = bus_rd && bus_byte;
    wr_data   = wr_ok && (off == OFF_DATA);
    wr_ctrl   = wr_ok && (off == OFF_CTRL);
    wr_xaddr  = wr_ok && (off == OFF_XADDR);
    wr_xdata  = wr_ok && (off == OFF_XDATA);
    rd_status = rd_ok && (off == OFF_STATUS);
  end

  logic [DATA_W-1:0] data_q, data_d;
  logic [DATA_W-1:0] xaddr_q, xaddr_d;
  logic [DATA_W-1:0] xdata_q, xdata_d;

  always_comb begin
    data_d  = wr_data  ? bus_wdata : data_q;
    xaddr_d = wr_xaddr ? bus_wdata : xaddr_q;
    xdata_d = wr_xdata ? bus_wdata : xdata_q;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      data_q  <= '0;
      xaddr_q <= '0;
      xdata_q <= '0;
    end else begin
      data_q  <= data_d;
      xaddr_q <= xaddr_d;
      xdata_q <= xdata_d;
    end
  end

  logic [DATA_W-1:0] ctrl_q;

  pport_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .wr_en (wr_ctrl),
    .wdata (bus_wdata),
    .ctrl_q(ctrl_q),
    .upd_q (pin_ctrl_upd)
  );

  logic ack_fall;

  pport_ack_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ack (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .ack_async(pin_ack),
    .ack_fall (ack_fall)
  );

  pport_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .set_req(ack_fall && ctrl_q[CTRL_ACKIE_BIT]),
    .clr_req(rd_status),
    .irq_q  (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      bus_rdata = RD_UNMAPPED;
      if (bus_byte) begin
        case (off)
          OFF_DATA:   bus_rdata = ctrl_q[CTRL_BIDIR_BIT] ? pin_din : data_q;
          OFF_STATUS: bus_rdata = pin_status;
          OFF_CTRL:   bus_rdata = ctrl_q;
          OFF_XADDR:  bus_rdata = xaddr_q;
          OFF_XDATA:  bus_rdata = xdata_q;
          default:    bus_rdata = RD_UNMAPPED;
        endcase
      end
    end
  end

  assign pin_dout = data_q;
  assign pin_doe  = ~ctrl_q[CTRL_BIDIR_BIT];
  assign pin_ctrl = ctrl_q;
endmodule

// File: rtl/pport_host_regs_chk.sv
module pport_host_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] off,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       bus_byte,
  input logic [7:0] bus_rdata,
  input logic [7:0] pin_dout,
  input logic [7:0] pin_ctrl,
  input logic       pin_ctrl_upd,
  input logic       ack_fall,
  input logic       irq
);
  AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_byte && off >= 3'd5) |-> bus_rdata == 8'hFF); // R2

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_byte && off == 3'd0) |=> $stable(pin_dout)); // R3

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_ctrl_upd |-> $stable(pin_ctrl)); // R6

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(pin_ctrl[4])); // R8

  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_byte && off == 3'd1 && !ack_fall) |=> !irq); // R9

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall && pin_ctrl[4]) |=> irq); // R9

  AST_NONBYTE_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_byte) |-> bus_rdata == 8'hFF); // R10
endmodule

bind pport_host_regs pport_host_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .off         (bus_addr[2:0]),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_byte    (bus_byte),
  .bus_rdata   (bus_rdata),
  .pin_dout    (pin_dout),
  .pin_ctrl    (pin_ctrl),
  .pin_ctrl_upd(pin_ctrl_upd),
  .ack_fall    (ack_fall),
  .irq         (irq)
);

// File: tb/pport_host_regs_bench.sv
`timescale 1ns/1ps
module pport_host_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_wr, bus_rd, bus_byte;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [7:0]  pin_dout, pin_din, pin_ctrl, pin_status;
  logic        pin_doe, pin_ctrl_upd, pin_ack, irq;

  always #5 clk = ~clk;

  pport_host_regs u_pport_host_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_byte(bus_byte), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_dout(pin_dout), .pin_doe(pin_doe),
    .pin_din(pin_din), .pin_ctrl(pin_ctrl), .pin_ctrl_upd(pin_ctrl_upd),
    .pin_status(pin_status), .pin_ack(pin_ack), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // fields: wr rd byte addr[16] wdata din status expected tag
  localparam int VW = 59;
  localparam int NV = 24;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1,1'b0,1'b1,16'h0000,8'h5A,8'h00,8'h00,8'h00,8'd3},  // R3 data write
    {1'b0,1'b1,1'b1,16'h0000,8'h00,8'hE7,8'h00,8'h5A,8'd4},  // R4 latch read
    {1'b1,1'b0,1'b1,16'h0002,8'h00,8'h00,8'h00,8'h00,8'd5},  // R5 write 00
    {1'b0,1'b1,1'b1,16'h0002,8'h00,8'h00,8'h00,8'hC0,8'd5},  // R5 forced ones
    {1'b1,1'b0,1'b1,16'h0002,8'h25,8'h00,8'h00,8'h00,8'd5},
    {1'b0,1'b1,1'b1,16'h0002,8'h00,8'h00,8'h00,8'hE5,8'd5},  // R5
    {1'b0,1'b1,1'b1,16'h0000,8'h00,8'h3C,8'h00,8'h3C,8'd4},  // R4 pins
    {1'b0,1'b1,1'b1,16'h0000,8'h00,8'hC3,8'h00,8'hC3,8'd4},  // R4 live
    {1'b1,1'b0,1'b1,16'h0002,8'h00,8'h00,8'h00,8'h00,8'd5},
    {1'b0,1'b1,1'b1,16'h0000,8'h00,8'h3C,8'h00,8'h5A,8'd4},  // R4 latch again
    {1'b1,1'b0,1'b1,16'h037B,8'h11,8'h00,8'h00,8'h00,8'd1},  // R1 high bits
    {1'b0,1'b1,1'b1,16'h0003,8'h00,8'h00,8'h00,8'h11,8'd12}, // R12
    {1'b1,1'b0,1'b1,16'h0004,8'h22,8'h00,8'h00,8'h00,8'd12},
    {1'b0,1'b1,1'b1,16'hF404,8'h00,8'h00,8'h00,8'h22,8'd1},  // R1
    {1'b1,1'b0,1'b1,16'h0005,8'h99,8'h00,8'h00,8'h00,8'd2},  // R2
    {1'b0,1'b1,1'b1,16'h0005,8'h00,8'h00,8'h00,8'hFF,8'd2},
    {1'b0,1'b1,1'b1,16'h0006,8'h00,8'h00,8'h00,8'hFF,8'd2},
    {1'b0,1'b1,1'b1,16'h0007,8'h00,8'h00,8'h00,8'hFF,8'd2},
    {1'b1,1'b0,1'b1,16'h0001,8'h00,8'h00,8'h00,8'h00,8'd2},
    {1'b0,1'b1,1'b1,16'h0001,8'h00,8'h00,8'hA5,8'hA5,8'd7},  // R7
    {1'b1,1'b0,1'b0,16'h0000,8'hFF,8'h00,8'h00,8'h00,8'd10}, // R10
    {1'b0,1'b1,1'b1,16'h0000,8'h00,8'h00,8'h00,8'h5A,8'd10},
    {1'b0,1'b1,1'b0,16'h0002,8'h00,8'h00,8'h00,8'hFF,8'd10},
    {1'b0,1'b1,1'b1,16'h0003,8'h00,8'h00,8'h00,8'h11,8'd2}   // R2 writes to 5/6/7/1 left regs
  };

  task automatic idle_bus();
    bus_wr = 1'b0; bus_rd = 1'b0; bus_byte = 1'b1;
    bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_byte = 1'b1;
    @(negedge clk);
    idle_bus();
  endtask

  task automatic read_chk(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_byte = 1'b1;
    #2 chk(req, bus_rdata, exp);
    @(negedge clk);
    idle_bus();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_bus();
    pin_din = 8'h00; pin_status = 8'h00; pin_ack = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    chk("R11 dout", pin_dout, 8'h00);
    chk("R11 ctrl", pin_ctrl, 8'hC0);
    chk("R11 irq", {7'd0, irq}, 8'h00);
    chk("R3 doe", {7'd0, pin_doe}, 8'h01);
    read_chk(16'h0003, 8'h00, "R11 xaddr");
    read_chk(16'h0004, 8'h00, "R11 xdata");

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      @(negedge clk);
      bus_wr = v[58]; bus_rd = v[57]; bus_byte = v[56];
      bus_addr = v[55:40]; bus_wdata = v[39:32];
      pin_din = v[31:24]; pin_status = v[23:16];
      #2;
      if (v[57]) chk($sformatf("R%0d vec%0d", v[7:0], i), bus_rdata, v[15:8]);
    end
    @(negedge clk);
    idle_bus();

    // R3 pins follow latch; data written via vectors was 5A
    chk("R3 dout", pin_dout, 8'h5A);

    // R6 update strobe only on change
    bus_write(16'h0002, 8'h20);
    chk("R6 upd on change", {7'd0, pin_ctrl_upd}, 8'h01);
    chk("R3 doe off", {7'd0, pin_doe}, 8'h00);
    bus_write(16'h0002, 8'hE0);
    chk("R6 no upd same", {7'd0, pin_ctrl_upd}, 8'h00);
    chk("R6 ctrl held", pin_ctrl, 8'hE0);

    // R8 disabled: ack edge without enable
    bus_write(16'h0002, 8'h00);
    @(negedge clk); pin_ack = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 gated", {7'd0, irq}, 8'h00);
    pin_ack = 1'b1;
    repeat (4) @(negedge clk);

    // R8 enabled
    bus_write(16'h0002, 8'h10);
    @(negedge clk); pin_ack = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 not yet", {7'd0, irq}, 8'h00);
    @(negedge clk);
    chk("R8 raised", {7'd0, irq}, 8'h01);
    pin_ack = 1'b1;
    repeat (4) @(negedge clk);

    // R10 non-byte status read keeps irq
    @(negedge clk);
    bus_addr = 16'h0001; bus_rd = 1'b1; bus_byte = 1'b0;
    @(negedge clk);
    idle_bus();
    chk("R10 irq kept", {7'd0, irq}, 8'h01);

    // R9 status read clears
    read_chk(16'h0001, 8'h00, "R7 status");
    chk("R9 cleared", {7'd0, irq}, 8'h00);

    // R9 collision: event and status read in same cycle
    @(negedge clk); pin_ack = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 16'h0001; bus_rd = 1'b1; bus_byte = 1'b1;
    @(negedge clk);
    idle_bus();
    chk("R9 set wins", {7'd0, irq}, 8'h01);
    pin_ack = 1'b1;
    repeat (4) @(negedge clk);
    read_chk(16'h0001, 8'h00, "R7 status");
    chk("R9 cleared after", {7'd0, irq}, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule